// File: doc/BRIEF.md
# Quad DAC serial command receiver

This block is the digital front end of a four-channel, 8-bit voltage DAC. A host drives three serial wires: a bit clock, a data line and a frame strobe. It also drives a separate update strobe. All four wires are sampled by a faster system clock. Each frame carries an 11-bit command. The first two bits are a channel select, the next is a range bit, and the last eight are the code, most significant bit first. On the falling edge of the frame strobe, the command goes into the selected channel's input latch.

Each channel holds its value twice: once in an input latch and once in an output latch. The output latch is what the analog stage would convert. The level of the update strobe decides when the output latch changes. If the strobe is low, a new command passes straight through to the output latch. If the strobe is high, new commands wait in the input latches. They all move to the output latches together when the strobe falls. For checking, each channel also reports its ideal output in units of one reference step: the code times one plus the range bit.

Top module: `qdac_cmd_rx`

## Requirements
- R1: After reset, every channel reports code 0, range 0 and level 0, and all input latches hold 0.
- R2: While `ser_load_i` is high, each falling edge of `ser_clk_i` shifts one `ser_dat_i` bit into the command register. The command is 11 bits, sent in this order: select[1], select[0], range, then code bit 7 down to code bit 0.
- R3: If more than 11 bits are shifted before `ser_load_i` falls, only the last 11 bits are used. A frame sent as two 8-clock bursts (16 bits) therefore loads its final 11 bits.
- R4: A falling edge of `ser_load_i` writes the command into the input latch of one channel only. Select 0 picks channel 0, 1 picks channel 1, 2 picks channel 2 and 3 picks channel 3. Channel c occupies slice c of `code_o`, `range_o` and `level_o`.
- R5: If `ser_hold_i` is low when `ser_load_i` falls, the selected channel's outputs take the new code and range on the third system clock edge after the change. The other channels keep their values.
- R6: If `ser_hold_i` is high when `ser_load_i` falls, no output changes.
- R7: A high-to-low transition of `ser_hold_i` copies all four input latches to the outputs in the same cycle.
- R8: `level_o` for a channel equals its code when range is 0, and twice its code when range is 1. The value is 10 bits wide, so the largest level is 510.
- R9: A rising edge of `ser_load_i` clears the command register. If fewer than 11 bits are shifted, the missing leading bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used to oversample the serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial bit clock; data is taken on its falling edge |
| ser_dat_i | input | 1 | Serial data, most significant bit first |
| ser_load_i | input | 1 | Frame strobe; high while shifting, falling edge loads the command |
| ser_hold_i | input | 1 | Update strobe; high defers output updates, a falling edge applies them to all channels |
| code_o | output | 4x8 | Code in each channel's output latch |
| range_o | output | 4 | Range bit in each channel's output latch |
| level_o | output | 4x10 | Ideal output per channel: code times (1 + range) |

## Verification
The checker assumes that every serial wire holds each level for longer than the synchronizer delay. Under that assumption each input edge shows up as exactly one detected event. It also assumes that data is stable around each falling edge of the bit clock, so the data sample lines up with that edge. The bench meets both assumptions: it holds each phase of the bit clock for three system clocks, changes data only together with a rising edge of the bit clock, and leaves several idle cycles around every strobe edge. Randomized frames vary the channel, range, code, hold mode and number of leading junk bits. Directed frames cover the short frame, the 16-bit burst and full-scale values.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int NUM_CH  = 4;
    localparam int CODE_W  = 8;
    localparam int SEL_W   = $clog2(NUM_CH);
    localparam int WORD_W  = SEL_W + 1 + CODE_W;
    localparam int LEVEL_W = CODE_W + 2;
    localparam int N_SER   = 4;

    // Positions of the oversampled serial inputs
    localparam int IN_SCLK = 0;
    localparam int IN_SDAT = 1;
    localparam int IN_LOAD = 2;
    localparam int IN_HOLD = 3;
    // Idle level of each serial input, used as the synchronizer reset value
    localparam logic [N_SER-1:0] IN_IDLE = 4'b0100;

    typedef struct packed {
        logic              rng;
        logic [CODE_W-1:0] code;
    } chan_val_t;

    // Bit order follows the wire: select first, then range, then code MSB first
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        chan_val_t        val;
    } cmd_word_t;

    function automatic logic [LEVEL_W-1:0] ideal_level(chan_val_t v);
        logic [LEVEL_W-1:0] base;
        base = LEVEL_W'(v.code);
        return v.rng ? (base << 1) : base;
    endfunction
endpackage

// File: rtl/qdac_sync_edge.sv
module qdac_sync_edge #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
            prev  <= RST_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], d};
            prev  <= chain[STAGES-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter
    import qdac_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      shift,
    input  logic      bit_in,
    output cmd_word_t word
);
    logic [WORD_W-1:0] sr;

    // Older bits fall off the top, so only the newest WORD_W bits remain
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sr <= '0;
        end else if (shift) begin
            sr <= {sr[WORD_W-2:0], bit_in};
        end
    end

    assign word = cmd_word_t'(sr);
endmodule

// File: rtl/qdac_chan_latch.sv
module qdac_chan_latch
    import qdac_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_in,
    input  logic      pass_now,
    input  logic      copy_all,
    input  chan_val_t new_val,
    output chan_val_t in_q,
    output chan_val_t out_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            in_q  <= '0;
            out_q <= '0;
        end else begin
            if (wr_in) begin
                in_q <= new_val;
            end
            // A direct write wins over the group copy
            if (wr_in && pass_now) begin
                out_q <= new_val;
            end else if (copy_all) begin
                out_q <= in_q;
            end
        end
    end
endmodule

// File: rtl/qdac_cmd_rx.sv
module qdac_cmd_rx
    import qdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ser_clk_i,
    input  logic                          ser_dat_i,
    input  logic                          ser_load_i,
    input  logic                          ser_hold_i,
    output logic [NUM_CH-1:0][CODE_W-1:0]  code_o,
    output logic [NUM_CH-1:0]             range_o,
    output logic [NUM_CH-1:0][LEVEL_W-1:0] level_o
);
    logic [N_SER-1:0] raw_in, in_lvl, in_rise, in_fall;
    logic             do_shift, load_fall, hold_fall, hold_lvl;
    logic [NUM_CH-1:0] in_wr;
    cmd_word_t        word;
    chan_val_t [NUM_CH-1:0] in_vals;
    chan_val_t [NUM_CH-1:0] out_vals;
    logic             unused_edges;

    assign raw_in = {ser_hold_i, ser_load_i, ser_dat_i, ser_clk_i};

    for (genvar i = 0; i < N_SER; i++) begin : g_sync
        qdac_sync_edge #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(IN_IDLE[i])
        ) sync_i (
            .clk (clk),
            .rst (rst),
            .d   (raw_in[i]),
            .lvl (in_lvl[i]),
            .rise(in_rise[i]),
            .fall(in_fall[i])
        );
    end

    assign do_shift  = in_fall[IN_SCLK] & in_lvl[IN_LOAD];
    assign load_fall = in_fall[IN_LOAD];
    assign hold_fall = in_fall[IN_HOLD];
    assign hold_lvl  = in_lvl[IN_HOLD];
    assign unused_edges = ^{in_rise[IN_SCLK], in_rise[IN_SDAT], in_fall[IN_SDAT],
                            in_rise[IN_HOLD]};

    qdac_shifter shift_i (
        .clk   (clk),
        .rst   (rst),
        .clear (in_rise[IN_LOAD]),
        .shift (do_shift),
        .bit_in(in_lvl[IN_SDAT]),
        .word  (word)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign in_wr[c] = load_fall && (word.sel == SEL_W'(c));

        qdac_chan_latch latch_i (
            .clk     (clk),
            .rst     (rst),
            .wr_in   (in_wr[c]),
            .pass_now(~hold_lvl),
            .copy_all(hold_fall),
            .new_val (word.val),
            .in_q    (in_vals[c]),
            .out_q   (out_vals[c])
        );

        assign code_o[c]  = out_vals[c].code;
        assign range_o[c] = out_vals[c].rng;
        assign level_o[c] = ideal_level(out_vals[c]);
    end
endmodule

// File: rtl/qdac_cmd_rx_chk.sv
module qdac_cmd_rx_chk
    import qdac_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic                         load_fall,
    input logic                         hold_fall,
    input logic                         hold_lvl,
    input logic [NUM_CH-1:0]            in_wr,
    input chan_val_t [NUM_CH-1:0]       in_vals,
    input chan_val_t [NUM_CH-1:0]       out_vals,
    input logic [NUM_CH-1:0][CODE_W-1:0] code_o,
    input logic [NUM_CH-1:0]            range_o
);
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (code_o == '0) && (range_o == '0) && (in_vals == '0));

    a_r4_single_write: assert property (@(posedge clk) disable iff (rst)
        $onehot0(in_wr));

    a_r6_hold_freeze: assert property (@(posedge clk) disable iff (rst)
        $past(hold_lvl) |-> $stable(code_o) && $stable(range_o));

    a_r5_quiet_no_event: assert property (@(posedge clk) disable iff (rst)
        (!$past(load_fall) && !$past(hold_fall)) |-> $stable(code_o) && $stable(range_o));

    a_r7_group_copy: assert property (@(posedge clk) disable iff (rst)
        ($past(hold_fall) && !$past(load_fall)) |-> (out_vals == $past(in_vals)));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_direct
        a_r5_direct_write: assert property (@(posedge clk) disable iff (rst)
            ($past(in_wr[c]) && !$past(hold_lvl)) |-> (out_vals[c] == in_vals[c]));
    end
endmodule

bind qdac_cmd_rx qdac_cmd_rx_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .load_fall(load_fall),
    .hold_fall(hold_fall),
    .hold_lvl (hold_lvl),
    .in_wr    (in_wr),
    .in_vals  (in_vals),
    .out_vals (out_vals),
    .code_o   (code_o),
    .range_o  (range_o)
);

// File: tb/qdac_cmd_rx_tb_top.sv
module qdac_cmd_rx_tb_top;
    import qdac_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic ser_load = 1'b1;
    logic ser_hold = 1'b0;
    logic [NUM_CH-1:0][CODE_W-1:0]  code_o;
    logic [NUM_CH-1:0]             range_o;
    logic [NUM_CH-1:0][LEVEL_W-1:0] level_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    int m_in_code[NUM_CH];
    int m_in_rng[NUM_CH];
    int m_out_code[NUM_CH];
    int m_out_rng[NUM_CH];
    bit m_hold = 0;

    always #10 clk = ~clk;

    qdac_cmd_rx dut_i (
        .clk       (clk),
        .rst       (rst),
        .ser_clk_i (ser_clk),
        .ser_dat_i (ser_dat),
        .ser_load_i(ser_load),
        .ser_hold_i(ser_hold),
        .code_o    (code_o),
        .range_o   (range_o),
        .level_o   (level_o)
    );

    function automatic int exp_level(int code, int rng);
        return rng != 0 ? code * 2 : code;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, string what, int ch, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s ch%0d %s: actual %0d expected %0d", req, ch, what, got, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int c = 0; c < NUM_CH; c++) begin
            chk(req, "code", c, int'(code_o[c]), m_out_code[c]);
            chk(req, "range", c, int'(range_o[c]), m_out_rng[c]);
            chk("R8", "level", c, int'(level_o[c]), exp_level(m_out_code[c], m_out_rng[c]));
        end
    endtask

    // Shifts the low n bits of bits, most significant first, then ends the frame
    task automatic send_frame(logic [31:0] bits, int n);
        logic [31:0] masked;
        int sel, rng, code;
        ser_load = 1'b1;
        tick(4);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = bits[i];
            ser_clk = 1'b1;
            tick(3);
            ser_clk = 1'b0;
            tick(3);
        end
        ser_load = 1'b0;
        tick(6);
        masked = (n >= 32) ? bits : (bits & ((32'd1 << n) - 32'd1));
        sel  = int'(masked[10:9]);
        rng  = int'(masked[8]);
        code = int'(masked[7:0]);
        m_in_code[sel] = code;
        m_in_rng[sel]  = rng;
        if (!m_hold) begin
            m_out_code[sel] = code;
            m_out_rng[sel]  = rng;
        end
    endtask

    task automatic cmd(int sel, int rng, int code);
        send_frame({21'd0, 2'(sel), 1'(rng), 8'(code)}, 11);
    endtask

    task automatic set_hold(bit v);
        if (m_hold && !v) begin
            for (int c = 0; c < NUM_CH; c++) begin
                m_out_code[c] = m_in_code[c];
                m_out_rng[c]  = m_in_rng[c];
            end
        end
        m_hold = v;
        ser_hold = v;
        tick(6);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1a2b3c4d));
        for (int c = 0; c < NUM_CH; c++) begin
            m_in_code[c] = 0; m_in_rng[c] = 0; m_out_code[c] = 0; m_out_rng[c] = 0;
        end
        tick(4);
        rst = 1'b0;
        tick(4);
        check_all("R1");

        // R5: direct update with hold low
        cmd(2, 1, 8'hA5);
        check_all("R5");
        // R4: each select value reaches its own channel
        for (int c = 0; c < NUM_CH; c++) begin
            cmd(c, c % 2, 16 + c * 37);
            check_all("R4");
        end
        // R8: full scale at double range
        cmd(3, 1, 8'hFF);
        check_all("R8");

        // R6: held updates do not reach the outputs
        set_hold(1'b1);
        cmd(0, 1, 8'h3C);
        cmd(1, 0, 8'hC3);
        check_all("R6");
        // R7: releasing the hold applies everything at once
        set_hold(1'b0);
        check_all("R7");

        // R3: two 8-clock bursts, leading five bits are junk
        send_frame(32'h0000_F9A7, 16);
        check_all("R3");
        // R9: short frame, missing leading bits read as zero
        cmd(0, 1, 8'h11);
        send_frame(32'h0000_00E4, 8);
        check_all("R9");

        // R2: random frames with junk prefixes and random hold use
        for (int it = 0; it < 40; it++) begin
            int extra;
            logic [31:0] bits;
            if (($urandom % 4) == 0) set_hold(~m_hold);
            extra = int'($urandom % 6);
            bits  = $urandom;
            send_frame(bits, 11 + extra);
            check_all("R2");
        end
        set_hold(1'b0);
        check_all("R7");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule